// File: doc/BRIEF.md
# Load/store data alignment formatter

This block sits between a 64-bit integer register file and a byte-addressed, little-endian data memory port. It adds a sign-extended 32-bit displacement to a 64-bit base register to form the effective address. For a store it places the register bytes into the memory lanes selected by the low address bits and drives one byte-enable bit for each of those lanes. For a load it takes the returned memory doubleword, moves the addressed bytes down to bit 0, and widens them to 64 bits.

Access sizes are 1, 2, 4 and 8 bytes. A separate forced-quad mode clears the three low address bits and performs an 8-byte access without trapping. The block decodes the upper address field into a user window, a kernel window or neither. An access that is naturally misaligned, or that falls in neither window, is not sent to memory. It is flagged for the slow path instead.

The request side is a single-cycle valid strobe, and the memory request is combinational from it. Load read data returns with its own valid strobe. The formatted result is registered and appears one cycle after that strobe.

Top module: `lsu_align_fmt`

## Requirements
- R1: `mem_addr_o` equals `base_i` plus `offset_i` sign-extended from bit 31 to 64 bits, taken modulo 2^64.
- R2: When `req_uq_i` is 1, bits [2:0] of `mem_addr_o` are zero and the access is 8 bytes regardless of `req_size_i`. Such an access is never flagged misaligned.
- R3: A fast-path store drives `mem_be_o` bits [L+N-1:L], where L = `mem_addr_o[2:0]` and N is the access size in bytes. Store byte k appears on `mem_wdata_o[8(L+k)+7 : 8(L+k)]`. Lanes that are not enabled carry zero.
- R4: The `req_size_i` encoding is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Loads of 1 and 2 bytes are zero-extended to 64 bits. Byte k of the access is taken from memory lane L+k.
- R5: A 4-byte load is sign-extended from its bit 31. An 8-byte load is returned unchanged.
- R6: A 2-, 4- or 8-byte access whose address has nonzero bits under the mask 1, 3 or 7 sets `misalign_o` and `slow_o`, and `mem_valid_o` stays 0. A 1-byte access is never misaligned.
- R7: `region_o` is 0 when address bits [63:40] are all zero and 1 when they are all ones. For any other value it is 2, and a valid request then raises `slow_o` with `mem_valid_o` held at 0.
- R8: `load_valid_o` is 1 exactly in the cycle after a cycle with `mem_rvalid_i` = 1. In that cycle `load_data_o` holds the formatted value of the read data, using the size and lane of the last load issued to memory.
- R9: Out of reset `load_valid_o` is 0. With `req_valid_i` at 0, `mem_valid_o`, `misalign_o` and `slow_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request strobe |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | Access size code (0:1B, 1:2B, 2:4B, 3:8B) |
| req_uq_i | input | 1 | Forced-quad mode: clear address bits [2:0], access 8 bytes |
| base_i | input | 64 | Base register value |
| offset_i | input | 32 | Signed displacement |
| store_data_i | input | 64 | Store source register |
| mem_valid_o | output | 1 | Fast-path memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 64 | Effective byte address |
| mem_be_o | output | 8 | Byte-lane enables |
| mem_wdata_o | output | 64 | Lane-aligned store data |
| misalign_o | output | 1 | Natural misalignment detected |
| slow_o | output | 1 | Access diverted to slow path |
| region_o | output | 2 | 0 user, 1 kernel, 2 other |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 64 | Memory read doubleword |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 64 | Formatted load result |

## Verification
The assertions check several rules on every cycle. A misaligned or out-of-window request never reaches memory. Forced-quad requests leave with a cleared low address and all eight enables set. The number of enabled lanes matches the access size. The address matches base plus displacement. The result strobe follows the read strobe by exactly one cycle. Only the bench scenarios can show that data bytes land in the right lanes and that the zero and sign extension are correct by size. They also show that a store followed by loads of every width returns consistent values from the bench's byte memory, including negative displacements and kernel-window addresses.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    ACC_B1 = 2'd0,
    ACC_B2 = 2'd1,
    ACC_B4 = 2'd2,
    ACC_B8 = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RG_USER = 2'd0,
    RG_KERN = 2'd1,
    RG_SLOW = 2'd2
  } region_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_align_pkg::*;
#(
  parameter int AW         = 64,
  parameter int OW         = 32,
  parameter int LANE_W     = 3,
  parameter int REGION_LSB = 40,
  parameter logic [AW-REGION_LSB-1:0] KERNEL_TOP = '1
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] offset_i,
  input  acc_size_e     size_i,
  input  logic          uq_i,
  output logic [AW-1:0] ea_o,
  output logic          misalign_o,
  output region_e       region_o
);
  localparam int TOP_W = AW - REGION_LSB;

  logic [AW-1:0]     ea_raw;
  logic [LANE_W-1:0] amask;
  logic [TOP_W-1:0]  top;

  assign ea_raw = base_i + {{(AW-OW){offset_i[OW-1]}}, offset_i};
  assign ea_o   = uq_i ? {ea_raw[AW-1:LANE_W], {LANE_W{1'b0}}} : ea_raw;

  always_comb begin
    unique case (size_i)
      ACC_B1:  amask = LANE_W'(0);
      ACC_B2:  amask = LANE_W'(1);
      ACC_B4:  amask = LANE_W'(3);
      default: amask = LANE_W'(7);
    endcase
  end

  // low address bits are the only page-offset bits a natural alignment test needs
  assign misalign_o = |(ea_o[LANE_W-1:0] & amask);

  assign top = ea_o[AW-1:REGION_LSB];

  always_comb begin
    if (top == '0)              region_o = RG_USER;
    else if (top == KERNEL_TOP) region_o = RG_KERN;
    else                        region_o = RG_SLOW;
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_align_pkg::*;
#(
  parameter int DW = 64
) (
  input  acc_size_e                   size_i,
  input  logic [$clog2(DW/8)-1:0]     lane_i,
  input  logic [DW-1:0]               data_i,
  output logic [DW/8-1:0]             be_o,
  output logic [DW-1:0]               wdata_o
);
  localparam int NB     = DW / 8;
  localparam int LANE_W = $clog2(NB);
  localparam int CW     = LANE_W + 2;

  logic [CW-1:0] nbytes;
  logic [CW-1:0] lane_ext;
  logic [DW-1:0] shifted;

  assign nbytes   = CW'(1) << size_i;
  assign lane_ext = CW'(lane_i);
  assign shifted  = data_i << {lane_i, 3'b000};

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign be_o[i] = (CW'(i) >= lane_ext) && (CW'(i) < lane_ext + nbytes);
    assign wdata_o[8*i +: 8] = be_o[i] ? shifted[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_align_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0]               rdata_i,
  input  acc_size_e                   size_i,
  input  logic [$clog2(DW/8)-1:0]     lane_i,
  output logic [DW-1:0]               result_o
);
  localparam int NB     = DW / 8;
  localparam int LANE_W = $clog2(NB);
  localparam int CW     = LANE_W + 2;
  localparam int SBIT   = DW / 2 - 1;

  logic [DW-1:0] shifted;
  logic [CW-1:0] nbytes;
  logic          fill;

  assign shifted = rdata_i >> {lane_i, 3'b000};
  assign nbytes  = CW'(1) << size_i;
  // only the half-width load widens with its sign
  assign fill    = (size_i == ACC_B4) & shifted[SBIT];

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign result_o[8*i +: 8] = (CW'(i) < nbytes) ? shifted[8*i +: 8] : {8{fill}};
  end
endmodule

// File: rtl/lsu_align_fmt.sv
module lsu_align_fmt
  import lsu_align_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int OFF_W      = 32,
  parameter int REGION_LSB = 40,
  parameter logic [DATA_W-REGION_LSB-1:0] KERNEL_TOP = '1,
  localparam int NB        = DATA_W / 8,
  localparam int LANE_W    = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_uq_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] store_data_i,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [NB-1:0]     mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              misalign_o,
  output logic              slow_o,
  output logic [1:0]        region_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              load_valid_o,
  output logic [DATA_W-1:0] load_data_o
);
  acc_size_e         eff_size;
  logic [DATA_W-1:0] ea;
  logic              mis;
  region_e           region;
  logic              slow;

  acc_size_e         pend_size_q;
  logic [LANE_W-1:0] pend_lane_q;
  logic [DATA_W-1:0] fmt_data;
  logic              load_valid_q;
  logic [DATA_W-1:0] load_data_q;

  assign eff_size = req_uq_i ? ACC_B8 : acc_size_e'(req_size_i);

  lsu_agen #(
    .AW(DATA_W), .OW(OFF_W), .LANE_W(LANE_W),
    .REGION_LSB(REGION_LSB), .KERNEL_TOP(KERNEL_TOP)
  ) u_agen (
    .base_i    (base_i),
    .offset_i  (offset_i),
    .size_i    (eff_size),
    .uq_i      (req_uq_i),
    .ea_o      (ea),
    .misalign_o(mis),
    .region_o  (region)
  );

  lsu_store_lanes #(.DW(DATA_W)) u_st (
    .size_i (eff_size),
    .lane_i (ea[LANE_W-1:0]),
    .data_i (store_data_i),
    .be_o   (mem_be_o),
    .wdata_o(mem_wdata_o)
  );

  assign slow        = mis | (region == RG_SLOW);
  assign misalign_o  = req_valid_i & mis;
  assign slow_o      = req_valid_i & slow;
  assign mem_valid_o = req_valid_i & ~slow;
  assign mem_we_o    = req_store_i;
  assign mem_addr_o  = ea;
  assign region_o    = region;

  // one load outstanding: remember how to format its return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_size_q <= ACC_B8;
      pend_lane_q <= '0;
    end else if (mem_valid_o && !req_store_i) begin
      pend_size_q <= eff_size;
      pend_lane_q <= ea[LANE_W-1:0];
    end
  end

  lsu_load_fmt #(.DW(DATA_W)) u_ld (
    .rdata_i (mem_rdata_i),
    .size_i  (pend_size_q),
    .lane_i  (pend_lane_q),
    .result_o(fmt_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_valid_q <= 1'b0;
      load_data_q  <= '0;
    end else begin
      load_valid_q <= mem_rvalid_i;
      if (mem_rvalid_i) load_data_q <= fmt_data;
    end
  end

  assign load_valid_o = load_valid_q;
  assign load_data_o  = load_data_q;
endmodule

// File: rtl/lsu_align_fmt_chk.sv
module lsu_align_fmt_chk #(
  parameter int DATA_W = 64,
  parameter int OFF_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_uq_i,
  input logic [1:0]        req_size_i,
  input logic [DATA_W-1:0] base_i,
  input logic [OFF_W-1:0]  offset_i,
  input logic              mem_valid_o,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic [DATA_W/8-1:0] mem_be_o,
  input logic              misalign_o,
  input logic              slow_o,
  input logic [1:0]        region_o,
  input logic              mem_rvalid_i,
  input logic              load_valid_o
);
  logic [DATA_W-1:0] ea_ref;
  int                n_ref;

  assign ea_ref = base_i + {{(DATA_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign n_ref  = req_uq_i ? 8 : (1 << req_size_i);

  a_r1_addr_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> mem_addr_o[DATA_W-1:3] == ea_ref[DATA_W-1:3]);

  a_r2_uq_full_quad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && req_uq_i) |-> (mem_addr_o[2:0] == 3'd0 && mem_be_o == '1 && !misalign_o));

  a_r3_lane_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> $countones(mem_be_o) == n_ref);

  a_r6_misalign_diverts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (slow_o && !mem_valid_o));

  a_r6_byte_never_misaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_uq_i && req_size_i == 2'd0) |-> !misalign_o);

  a_r7_other_region_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && region_o == 2'd2) |-> (slow_o && !mem_valid_o));

  a_r8_result_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |=> load_valid_o);

  a_r8_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rvalid_i |=> !load_valid_o);

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!mem_valid_o && !misalign_o && !slow_o));
endmodule

bind lsu_align_fmt lsu_align_fmt_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_uq_i    (req_uq_i),
  .req_size_i  (req_size_i),
  .base_i      (base_i),
  .offset_i    (offset_i),
  .mem_valid_o (mem_valid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_be_o    (mem_be_o),
  .misalign_o  (misalign_o),
  .slow_o      (slow_o),
  .region_o    (region_o),
  .mem_rvalid_i(mem_rvalid_i),
  .load_valid_o(load_valid_o)
);

// File: tb/sim_lsu_align_fmt.sv
`timescale 1ns/100ps
module sim_lsu_align_fmt;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_store_i = 1'b0, req_uq_i = 1'b0;
  logic [1:0]  req_size_i = 2'd0;
  logic [63:0] base_i = '0, store_data_i = '0, mem_rdata_i = '0;
  logic [31:0] offset_i = '0;
  logic        mem_rvalid_i = 1'b0;
  logic        mem_valid_o, mem_we_o, misalign_o, slow_o, load_valid_o;
  logic [63:0] mem_addr_o, mem_wdata_o, load_data_o;
  logic [7:0]  mem_be_o;
  logic [1:0]  region_o;

  int n_tests = 0, n_fail = 0;
  bit running = 0;
  logic lv_exp;
  logic [63:0] mem [0:127];

  always #2.5 clk_i = ~clk_i;

  lsu_align_fmt u0 (.*);

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // bench memory: byte-enabled doubleword writes
  always @(posedge clk_i)
    if (rst_ni && mem_valid_o && mem_we_o)
      for (int b = 0; b < 8; b++)
        if (mem_be_o[b]) mem[mem_addr_o[9:3]][8*b +: 8] <= mem_wdata_o[8*b +: 8];

  // R8 reference: result strobe is the read strobe delayed one clock
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lv_exp <= 1'b0; else lv_exp <= mem_rvalid_i;
  always @(negedge clk_i)
    if (running) chk("R8", "load_valid_o", 64'(load_valid_o), 64'(lv_exp));

  task automatic access(input bit st, input logic [1:0] sz, input bit uq,
                        input logic [63:0] base, input logic [31:0] off,
                        input logic [63:0] sd, input string rq);
    logic [63:0] ea, exp_wd, word, v, exp_ld;
    logic [7:0]  exp_be;
    int n, lane, rg;
    bit mis, fast;
    @(negedge clk_i);
    req_valid_i = 1; req_store_i = st; req_size_i = sz; req_uq_i = uq;
    base_i = base; offset_i = off; store_data_i = sd;
    ea = base + {{32{off[31]}}, off};
    if (uq) ea[2:0] = 3'd0;
    n = uq ? 8 : (1 << sz);
    lane = int'(ea[2:0]);
    mis = (lane % n) != 0;
    if (ea[63:40] == 24'h0) rg = 0;
    else if (ea[63:40] == 24'hFFFFFF) rg = 1;
    else rg = 2;
    fast = !mis && rg != 2;
    #1;
    chk(rq, "mem_addr_o", mem_addr_o, ea);
    chk(rq, "misalign_o", 64'(misalign_o), 64'(mis));
    chk(rq, "region_o", 64'(region_o), 64'(rg));
    chk(rq, "slow_o", 64'(slow_o), 64'(!fast));
    chk(rq, "mem_valid_o", 64'(mem_valid_o), 64'(fast));
    if (fast && st) begin
      exp_be = 8'h00; exp_wd = '0;
      for (int k = 0; k < n; k++) begin
        exp_be[lane+k] = 1'b1;
        exp_wd[8*(lane+k) +: 8] = sd[8*k +: 8];
      end
      chk(rq, "mem_be_o", 64'(mem_be_o), 64'(exp_be));
      chk(rq, "mem_wdata_o", mem_wdata_o, exp_wd);
    end
    @(negedge clk_i);
    req_valid_i = 0;
    if (fast && !st) begin
      word = mem[ea[9:3]];
      mem_rvalid_i = 1; mem_rdata_i = word;
      exp_ld = '0;
      for (int k = 0; k < n; k++) exp_ld[8*k +: 8] = word[8*(lane+k) +: 8];
      if (n == 4 && exp_ld[31]) exp_ld[63:32] = '1;
      v = exp_ld;
      @(negedge clk_i);
      mem_rvalid_i = 0; mem_rdata_i = '0;
      #1;
      chk(rq, "load_data_o", load_data_o, v);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 64'h0F1E_2D3C_4B5A_6978 ^ (64'(i) * 64'h0101_0101_0101_0101);
    repeat (3) @(negedge clk_i);
    chk("R9", "load_valid_o reset", 64'(load_valid_o), 64'h0);
    chk("R9", "mem_valid_o idle", 64'(mem_valid_o), 64'h0);
    chk("R9", "slow_o idle", 64'(slow_o), 64'h0);
    rst_ni = 1;
    @(negedge clk_i);
    running = 1;

    access(1, 2'd3, 0, 64'h100, 32'h0, 64'h8877_6655_4433_2211, "R1 R3 store quad");
    access(0, 2'd3, 0, 64'h100, 32'h0, '0, "R5 quad load");
    access(0, 2'd0, 0, 64'h100, 32'h5, '0, "R4 byte lane5");
    access(0, 2'd0, 0, 64'h107, 32'h0, '0, "R4 byte msb set");
    access(0, 2'd1, 0, 64'h106, 32'h0, '0, "R4 half zero-ext");
    access(0, 2'd2, 0, 64'h104, 32'h0, '0, "R5 word sign-ext neg");
    access(0, 2'd2, 0, 64'h100, 32'h0, '0, "R5 word positive");
    access(1, 2'd0, 0, 64'h108, 32'h3, 64'hFFFF_FFFF_FFFF_FFAB, "R3 store byte lane3");
    access(1, 2'd1, 0, 64'h10C, 32'h0, 64'h5555_5555_5555_1234, "R3 store half lane4");
    access(1, 2'd2, 0, 64'h110, 32'h4, 64'h0000_0000_CAFE_F00D, "R3 store word lane4");
    access(0, 2'd3, 0, 64'h108, 32'h0, '0, "R3 readback quad");
    access(0, 2'd2, 0, 64'h114, 32'h0, '0, "R5 word readback sign");
    access(0, 2'd2, 0, 64'h120, 32'hFFFF_FFE4, '0, "R1 negative offset");
    access(0, 2'd0, 0, 64'h0, 32'hFFFF_FFFF, '0, "R1 R7 wrap to kernel");
    access(0, 2'd0, 1, 64'h105, 32'h0, '0, "R2 uq load");
    access(1, 2'd1, 1, 64'h13F, 32'h0, 64'h1122_3344_5566_7788, "R2 uq store");
    access(0, 2'd3, 0, 64'h138, 32'h0, '0, "R2 uq readback");
    access(0, 2'd1, 0, 64'h101, 32'h0, '0, "R6 half misaligned");
    access(0, 2'd2, 0, 64'h106, 32'h0, '0, "R6 word misaligned");
    access(1, 2'd3, 0, 64'h104, 32'h0, 64'h1, "R6 quad misaligned");
    access(0, 2'd3, 0, 64'h100, 32'h0, '0, "R6 memory untouched");
    access(0, 2'd0, 0, 64'h103, 32'h0, '0, "R6 byte never misaligned");
    access(1, 2'd3, 0, 64'hFFFF_FF00_0000_0200, 32'h0, 64'hDEAD_BEEF_0BAD_F00D, "R7 kernel store");
    access(0, 2'd2, 0, 64'hFFFF_FF00_0000_0200, 32'h4, '0, "R7 kernel load");
    access(1, 2'd3, 0, 64'h0000_0100_0000_0000, 32'h0, 64'h77, "R7 other region");
    access(0, 2'd3, 0, 64'h0, 32'h0, '0, "R7 memory untouched");

    repeat (2) @(negedge clk_i);
    running = 0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule